// File: doc/BRIEF.md
# Bus-Width Matching Port Adapter with Lane Swapping

The adapter sits between a fixed internal word of four 9-bit lanes (36 bits) and an external port. The port can run 36, 18 or 9 bits wide, and the width can be changed while the design runs. Each 9-bit lane carries eight data bits and one parity bit. The adapter moves each lane without looking inside it.

In the outbound direction, a word taken from an internal source is first lane-swapped as a whole. It is then cut into one, two or four port transfers, in big-endian or little-endian lane order. In the inbound direction, port transfers are packed back into a whole word, the same swap is undone, and the word is offered to an internal sink. A narrow transfer uses the low bits of the 36-bit port bus. The source is popped, or the sink is pushed, only when the last transfer of a word completes. Width, endian and swap settings are sampled once per word, at the word's first transfer. Reset discards any half-sent or half-collected word.

The outbound side has two states. `TX_IDLE` moves to `TX_SEND` when the source has a word, latching the swapped word and the settings. `TX_SEND` moves back to `TX_IDLE` when the last beat is accepted. The inbound side has three states. `RX_IDLE` moves on its first accepted beat: to `RX_HOLD` if that beat is the last one, otherwise to `RX_FILL`. `RX_FILL` moves to `RX_HOLD` when the last beat is accepted. `RX_HOLD` moves to `RX_IDLE` when the sink accepts the word.

Top module: `bm_port_adapter`

## Requirements
- R1: The width code sets the transfers per word: `cfg_width` 2'b00 gives one 36-bit transfer, 2'b01 gives two 18-bit transfers on bits [17:0], and 2'b10 or 2'b11 gives four 9-bit transfers on bits [8:0]. Unused `pout_data` bits are 0, and unused `pin_data` bits are ignored.
- R2: With `cfg_big_endian`=1, the most significant half or lane (lane 0 = bits [35:27]) is transferred first.
- R3: With `cfg_big_endian`=0, the least significant half or lane is transferred first.
- R4: Before serializing, the word's lanes are rearranged by `cfg_swap`, with output lanes listed from lane 0: 0 keeps 0,1,2,3; 1 gives 3,2,1,0; 2 gives 2,3,0,1; 3 gives 1,0,3,2. This works with every width and endian setting.
- R5: Inbound transfers sent in the order and swap that the same settings produce outbound are rebuilt into the original word on `snk_data`.
- R6: `src_pop` pulses only in the cycle the last transfer of a word is accepted. `snk_valid` rises only in the cycle after the last inbound transfer is accepted.
- R7: A stalled output holds its value: `pout_data` while `pout_ready`=0, and `snk_data` while `snk_ready`=0.
- R8: A change of width, endian or swap made during a word takes effect only from the next word.
- R9: Reset clears `pout_valid`, `src_pop` and `snk_valid`, sets `pin_ready`, and discards any partial word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_width | input | 2 | Port width code |
| cfg_big_endian | input | 1 | 1 = most significant part first |
| cfg_swap | input | 2 | Lane swap mode |
| src_data | input | 36 | Internal word to send |
| src_valid | input | 1 | Internal source has a word |
| src_pop | output | 1 | Internal word consumed |
| pout_data | output | 36 | Outbound port data |
| pout_valid | output | 1 | Outbound transfer offered |
| pout_ready | input | 1 | Port accepts outbound transfer |
| pin_data | input | 36 | Inbound port data |
| pin_valid | input | 1 | Inbound transfer offered |
| pin_ready | output | 1 | Adapter accepts inbound transfer |
| snk_data | output | 36 | Rebuilt internal word |
| snk_valid | output | 1 | Rebuilt word available |
| snk_ready | input | 1 | Internal sink accepts the word |

## Verification
The assertions assume the following about the inputs:
- `src_data` stays constant while `src_valid` is held, until `src_pop` is seen.
- The sink and the port follow a valid/ready discipline.
- Configuration changes may come at any time.

The stimulus drives every input half a cycle away from the sampling edge. It releases `src_valid` in the cycle after a pop, so a word is never latched twice. Configuration changes in the middle of a word are made only after that word's first transfer has been accepted.

// File: rtl/bm_pkg.sv
package bm_pkg;

    typedef struct packed {
        logic [1:0] width;
        logic       big;
        logic [1:0] swap;
    } bm_cfg_t;

    // index of the final beat for a width code
    function automatic logic [1:0] last_beat(input logic [1:0] width);
        unique case (width)
            2'b00:   return 2'd0;
            2'b01:   return 2'd1;
            default: return 2'd3;
        endcase
    endfunction

    // each swap mode maps lane i to lane i xor key
    function automatic logic [1:0] lane_key(input logic [1:0] mode);
        unique case (mode)
            2'd0: return 2'd0;
            2'd1: return 2'd3;
            2'd2: return 2'd2;
            2'd3: return 2'd1;
        endcase
    endfunction

    // which part of the word (0 = most significant) a beat carries
    function automatic logic [1:0] group_of(input bm_cfg_t c, input logic [1:0] beat);
        return c.big ? beat : last_beat(c.width) - beat;
    endfunction

endpackage

// File: rtl/bm_lane_swap.sv
module bm_lane_swap #(
    parameter int LANE_W = 9
) (
    input  logic [1:0]          mode,
    input  logic [4*LANE_W-1:0] din,
    output logic [4*LANE_W-1:0] dout
);
    localparam int LANES = 4;

    logic [1:0] key;
    assign key = bm_pkg::lane_key(mode);

    always_comb begin
        dout = '0;
        for (int i = 0; i < LANES; i++) begin
            dout[(LANES-1-i)*LANE_W +: LANE_W] =
                din[(LANES-1-int'(2'(i) ^ key))*LANE_W +: LANE_W];
        end
    end
endmodule

// File: rtl/bm_tx_unpack.sv
module bm_tx_unpack
    import bm_pkg::*;
#(
    parameter int LANE_W = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  bm_cfg_t             cfg,
    input  logic [4*LANE_W-1:0] src_data,
    input  logic                src_valid,
    output logic                src_pop,
    output logic [4*LANE_W-1:0] pout_data,
    output logic                pout_valid,
    input  logic                pout_ready
);
    localparam int W    = 4*LANE_W;
    localparam int HALF = 2*LANE_W;

    typedef enum logic {TX_IDLE, TX_SEND} tx_state_e;

    tx_state_e      state_q, state_d;
    bm_cfg_t        cfg_q;
    logic [W-1:0]   word_q, swapped;
    logic [1:0]     beat_q, grp;
    logic           last;

    bm_lane_swap #(.LANE_W(LANE_W)) u_swap (
        .mode(cfg.swap), .din(src_data), .dout(swapped)
    );

    assign last = (beat_q == last_beat(cfg_q.width));
    assign grp  = group_of(cfg_q, beat_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: if (src_valid)          state_d = TX_SEND;
            TX_SEND: if (pout_ready && last) state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            cfg_q   <= '0;
            word_q  <= '0;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == TX_IDLE && src_valid) begin
                cfg_q  <= cfg;
                word_q <= swapped;
                beat_q <= '0;
            end else if (state_q == TX_SEND && pout_ready) begin
                beat_q <= last ? 2'd0 : beat_q + 2'd1;
            end
        end
    end

    always_comb begin
        pout_valid = 1'b0;
        src_pop    = 1'b0;
        pout_data  = '0;
        unique case (state_q)
            TX_IDLE: ;
            TX_SEND: begin
                pout_valid = 1'b1;
                src_pop    = pout_ready && last;
                unique case (cfg_q.width)
                    2'b00:   pout_data = word_q;
                    2'b01:   pout_data[HALF-1:0] = word_q[(1-int'(grp))*HALF +: HALF];
                    default: pout_data[LANE_W-1:0] = word_q[(3-int'(grp))*LANE_W +: LANE_W];
                endcase
            end
        endcase
    end

    // R6: the source is popped only together with an accepted transfer
    a_r6_pop_with_transfer: assert property (@(posedge clk) disable iff (!rst_n)
        src_pop |-> (pout_valid && pout_ready));

    // R7: a stalled outbound transfer keeps its data
    a_r7_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pout_valid && !pout_ready) |=> (pout_valid && $stable(pout_data)));
endmodule

// File: rtl/bm_rx_pack.sv
module bm_rx_pack
    import bm_pkg::*;
#(
    parameter int LANE_W = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  bm_cfg_t             cfg,
    input  logic [4*LANE_W-1:0] pin_data,
    input  logic                pin_valid,
    output logic                pin_ready,
    output logic [4*LANE_W-1:0] snk_data,
    output logic                snk_valid,
    input  logic                snk_ready
);
    localparam int W    = 4*LANE_W;
    localparam int HALF = 2*LANE_W;

    typedef enum logic [1:0] {RX_IDLE, RX_FILL, RX_HOLD} rx_state_e;

    rx_state_e      state_q, state_d;
    bm_cfg_t        cfg_q, cfg_eff;
    logic [W-1:0]   acc_q, acc_d;
    logic [1:0]     beat_q, beat_eff, grp;
    logic           last, take;

    // settings are taken live for the first beat, latched for the rest
    assign cfg_eff  = (state_q == RX_IDLE) ? cfg : cfg_q;
    assign beat_eff = (state_q == RX_IDLE) ? 2'd0 : beat_q;
    assign grp      = group_of(cfg_eff, beat_eff);
    assign last     = (beat_eff == last_beat(cfg_eff.width));
    assign take     = pin_valid && pin_ready;

    always_comb begin
        acc_d = acc_q;
        unique case (cfg_eff.width)
            2'b00:   acc_d = pin_data;
            2'b01:   acc_d[(1-int'(grp))*HALF +: HALF] = pin_data[HALF-1:0];
            default: acc_d[(3-int'(grp))*LANE_W +: LANE_W] = pin_data[LANE_W-1:0];
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE, RX_FILL: if (take) state_d = last ? RX_HOLD : RX_FILL;
            RX_HOLD:          if (snk_ready) state_d = RX_IDLE;
            default:          state_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            cfg_q   <= '0;
            acc_q   <= '0;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            if (take) begin
                acc_q  <= acc_d;
                beat_q <= last ? 2'd0 : beat_eff + 2'd1;
                if (state_q == RX_IDLE) cfg_q <= cfg;
            end
        end
    end

    bm_lane_swap #(.LANE_W(LANE_W)) u_unswap (
        .mode(cfg_q.swap), .din(acc_q), .dout(snk_data)
    );

    always_comb begin
        pin_ready = 1'b1;
        snk_valid = 1'b0;
        unique case (state_q)
            RX_IDLE, RX_FILL: ;
            RX_HOLD: begin
                pin_ready = 1'b0;
                snk_valid = 1'b1;
            end
            default: ;
        endcase
    end

    // R6: a word appears only right after an accepted inbound transfer
    a_r6_push_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(snk_valid) |-> $past(pin_valid && pin_ready));

    // R7: a word refused by the sink stays unchanged
    a_r7_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (snk_valid && !snk_ready) |=> (snk_valid && $stable(snk_data)));
endmodule

// File: rtl/bm_port_adapter.sv
module bm_port_adapter
    import bm_pkg::*;
#(
    parameter int LANE_W = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          cfg_width,
    input  logic                cfg_big_endian,
    input  logic [1:0]          cfg_swap,
    input  logic [4*LANE_W-1:0] src_data,
    input  logic                src_valid,
    output logic                src_pop,
    output logic [4*LANE_W-1:0] pout_data,
    output logic                pout_valid,
    input  logic                pout_ready,
    input  logic [4*LANE_W-1:0] pin_data,
    input  logic                pin_valid,
    output logic                pin_ready,
    output logic [4*LANE_W-1:0] snk_data,
    output logic                snk_valid,
    input  logic                snk_ready
);
    bm_cfg_t cfg;
    assign cfg = '{width: cfg_width, big: cfg_big_endian, swap: cfg_swap};

    bm_tx_unpack #(.LANE_W(LANE_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .cfg(cfg),
        .src_data(src_data), .src_valid(src_valid), .src_pop(src_pop),
        .pout_data(pout_data), .pout_valid(pout_valid), .pout_ready(pout_ready)
    );

    bm_rx_pack #(.LANE_W(LANE_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .cfg(cfg),
        .pin_data(pin_data), .pin_valid(pin_valid), .pin_ready(pin_ready),
        .snk_data(snk_data), .snk_valid(snk_valid), .snk_ready(snk_ready)
    );
endmodule

// File: tb/test_bm_port_adapter.sv
module test_bm_port_adapter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_width = 2'b00;
    logic        cfg_big_endian = 1'b1;
    logic [1:0]  cfg_swap = 2'd0;
    logic [35:0] src_data = '0;
    logic        src_valid = 1'b0;
    logic        src_pop;
    logic [35:0] pout_data;
    logic        pout_valid;
    logic        pout_ready = 1'b0;
    logic [35:0] pin_data = '0;
    logic        pin_valid = 1'b0;
    logic        pin_ready;
    logic [35:0] snk_data;
    logic        snk_valid;
    logic        snk_ready = 1'b0;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;
    logic [35:0] exp_b [4];
    int exp_n;

    always #10 clk = ~clk;

    bm_port_adapter i_bm_port_adapter (.*);

    task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // behavioural model of the port transfers for one word
    task automatic make_beats(input logic [35:0] w, input logic [1:0] wd, input logic big, input logic [1:0] sw);
        logic [8:0] l [4];
        logic [8:0] s [4];
        for (int i = 0; i < 4; i++) l[i] = w[35-9*i -: 9];
        case (sw)
            2'd0: begin s[0]=l[0]; s[1]=l[1]; s[2]=l[2]; s[3]=l[3]; end
            2'd1: begin s[0]=l[3]; s[1]=l[2]; s[2]=l[1]; s[3]=l[0]; end
            2'd2: begin s[0]=l[2]; s[1]=l[3]; s[2]=l[0]; s[3]=l[1]; end
            default: begin s[0]=l[1]; s[1]=l[0]; s[2]=l[3]; s[3]=l[2]; end
        endcase
        for (int i = 0; i < 4; i++) exp_b[i] = '0;
        if (wd == 2'b00) begin
            exp_n = 1; exp_b[0] = {s[0], s[1], s[2], s[3]};
        end else if (wd == 2'b01) begin
            exp_n = 2;
            exp_b[big ? 0 : 1] = {18'd0, s[0], s[1]};
            exp_b[big ? 1 : 0] = {18'd0, s[2], s[3]};
        end else begin
            exp_n = 4;
            for (int k = 0; k < 4; k++) exp_b[k] = {27'd0, big ? s[k] : s[3-k]};
        end
    endtask

    function automatic string tag_of();
        if (cfg_swap != 0) return "R4";
        if (cfg_width == 2'b00) return "R1";
        return cfg_big_endian ? "R2" : "R3";
    endfunction

    task automatic flip_cfg();
        cfg_width = (cfg_width == 2'b00) ? 2'b10 : 2'b00;
        cfg_big_endian = ~cfg_big_endian;
        cfg_swap = cfg_swap + 2'd1;
    endtask

    task automatic tx_word(input logic [35:0] w, input bit mid_change, input int stop_after);
        int idx = 0;
        bit stalled = 0;
        logic [35:0] held = '0;
        string tg = tag_of();
        make_beats(w, cfg_width, cfg_big_endian, cfg_swap);
        src_data = w;
        src_valid = 1'b1;
        while (idx < exp_n && idx != stop_after) begin
            @(negedge clk);
            pout_ready = (cyc % 3) != 2;
            cyc++;
            #1;
            if (stalled) chk(pout_valid && pout_data == held, "R7 tx hold", pout_data, held);
            stalled = 0;
            if (pout_valid && !pout_ready) begin
                held = pout_data; stalled = 1;
                chk(!src_pop, "R6 pop while stalled", 36'(src_pop), 36'd0);
            end
            if (pout_valid && pout_ready) begin
                chk(pout_data == exp_b[idx], mid_change ? "R8 tx" : tg, pout_data, exp_b[idx]);
                chk(src_pop == (idx == exp_n-1), "R6 pop", 36'(src_pop), 36'(idx == exp_n-1));
                idx++;
                if (mid_change && idx == 1) flip_cfg();
            end
        end
        @(negedge clk);
        src_valid = 1'b0;
        pout_ready = 1'b0;
    endtask

    task automatic rx_word(input logic [35:0] w, input bit mid_change, input int stop_after);
        logic [35:0] junk;
        make_beats(w, cfg_width, cfg_big_endian, cfg_swap);
        junk = (cfg_width == 2'b00) ? 36'd0 :
               (cfg_width == 2'b01) ? (36'hA_5C3E_96F1 & ~36'h3FFFF) : (36'hA_5C3E_96F1 & ~36'h1FF);
        snk_ready = 1'b0;
        for (int k = 0; k < exp_n; k++) begin
            if (k == stop_after) return;
            @(negedge clk);
            if (mid_change && k == 1) flip_cfg();
            pin_valid = 1'b1;
            pin_data = exp_b[k] | junk;   // R1: upper bits must be ignored
            #1;
            chk(pin_ready && !snk_valid, "R6 early push", 36'(snk_valid), 36'd0);
        end
        @(negedge clk);
        pin_valid = 1'b0;
        pin_data = '0;
        #1;
        chk(snk_valid && snk_data == w, mid_change ? "R8 rx" : "R5 rebuild", snk_data, w);
        @(negedge clk);
        snk_ready = 1'b1;
        #1;
        chk(snk_valid && snk_data == w, "R7 rx hold", snk_data, w);
        @(negedge clk);
        snk_ready = 1'b0;
        #1;
        chk(!snk_valid, "R6 single push", 36'(snk_valid), 36'd0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        src_valid = 1'b0;
        pin_valid = 1'b0;
        pout_ready = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        chk(!pout_valid && !src_pop && !snk_valid && pin_ready, "R9 reset state",
            {32'd0, pout_valid, src_pop, snk_valid, pin_ready}, 36'd1);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset();
        for (int wd = 0; wd < 4; wd++) begin
            for (int b = 0; b < 2; b++) begin
                for (int sw = 0; sw < 4; sw++) begin
                    cfg_width = 2'(wd);
                    cfg_big_endian = b[0];
                    cfg_swap = 2'(sw);
                    tx_word(36'h1_2345_6789 ^ {4'(wd), 28'd0, 4'(sw)}, 0, -1);
                    rx_word(36'h9_8A7B_6C5D ^ {8'(sw), 28'(wd*3+b)}, 0, -1);
                end
            end
        end
        // R8: settings changed mid-word apply from the next word
        cfg_width = 2'b10; cfg_big_endian = 1'b1; cfg_swap = 2'd0;
        tx_word(36'hF_0E1D_2C3B, 1, -1);
        tx_word(36'h4_5566_7788, 0, -1);
        cfg_width = 2'b01; cfg_big_endian = 1'b0; cfg_swap = 2'd2;
        rx_word(36'h3_CAFE_BEEF, 1, -1);
        rx_word(36'h7_1357_9BDF, 0, -1);
        // R9: partial words discarded by reset
        cfg_width = 2'b10; cfg_big_endian = 1'b0; cfg_swap = 2'd1;
        tx_word(36'hA_AAAA_5555, 0, 2);
        do_reset();
        tx_word(36'h0_F0F0_1234, 0, -1);
        rx_word(36'hB_BBBB_CCCC, 0, 2);
        do_reset();
        rx_word(36'h2_4681_3579, 0, -1);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule